// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block tracks loads that a compiler has hoisted above stores it could not prove independent. When such a hoisted load issues, it records its byte address, its access size and the number of the register it writes. Every later store is compared against all live records at once, and any record whose byte range the store touches is dropped. Where the load originally stood, a check operation names the destination register. If a record for that register is still present, no store disturbed the early load and its value may be used. If the record is gone, the pipeline must re-execute the load, or run recovery code for the load and everything computed from it.

A successful check consumes its record. Losing a record for any other reason is always safe, because it can only produce a spurious failure and never a false success. So when the table is full, a new load takes over a slot and nothing is ever refused. The memory datapath and the recovery path sit outside this block.

Top module: `spec_load_table`

## Requirements
- R1: After reset no record is live. A check issued right after reset reports a miss, and `rsp_valid` stays low while no check is issued.
- R2: A check presented on `chk_valid` in one cycle is answered by `rsp_valid` high in the next cycle. `rsp_hit` is high when a live record exists for `chk_reg` and the store of the same cycle does not remove it.
- R3: A check for a register that has no live record reports a miss and leaves the table unchanged.
- R4: A successful check removes its record, so a repeated check for the same register misses.
- R5: A store covers bytes `st_addr` to `st_addr + 2^st_size - 1`, where size code 0, 1, 2, 3 means 1, 2, 4, 8 bytes, and a record covers its own range by the same rule. The store removes every live record whose range shares at least one byte with its own. Records that share no byte stay live.
- R6: A load for a register that already has a live record overwrites that record, so only the newest address and size of that register count. No two live records ever name the same register.
- R7: A load is placed, in this order of preference, in the slot of the live record for the same register, then in the lowest-numbered free slot, then in the slot named by a replacement pointer. The pointer starts at slot 0 after reset and advances by one, wrapping after the last slot, only when it is used. The table has `ENTRIES` slots.
- R8: When a store and a check arrive in the same cycle, the store's removals apply first, so a check whose record the store overlaps reports a miss.
- R9: A load presented in the same cycle as a store or a check is entered after both of them. That store does not remove the new record, and that check does not see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_valid | input | 1 | A hoisted load records itself this cycle |
| ld_addr | input | AW | Byte address of the load |
| ld_size | input | 2 | Load size code (0..3 for 1, 2, 4, 8 bytes) |
| ld_reg | input | RW | Destination register of the load |
| st_valid | input | 1 | A store is presented this cycle |
| st_addr | input | AW | Byte address of the store |
| st_size | input | 2 | Store size code (0..3 for 1, 2, 4, 8 bytes) |
| chk_valid | input | 1 | A check is presented this cycle |
| chk_reg | input | RW | Register named by the check |
| rsp_valid | output | 1 | Answer to the check of the previous cycle |
| rsp_hit | output | 1 | High when that check found its record |

## Verification
The assertions watch, on every cycle, that each check gets exactly one response one cycle later, that the table is empty when reset releases, that a hit and a store never grow the number of live records, and that no register is named by two live records. Only the bench's scenarios can show which records a given store removes, because that depends on range arithmetic across sizes and on partial overlaps at both ends of a range. The same holds for the slot a load lands in once the table is full, and for the order of events within one cycle. For this the bench keeps its own model of the table and runs it against directed cases and a long random mix over a narrow address window.

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES = 16,
  parameter int AW      = 32,
  parameter int RW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_size,
  input  logic [RW-1:0] ld_reg,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic          chk_valid,
  input  logic [RW-1:0] chk_reg,
  output logic          rsp_valid,
  output logic          rsp_hit
);
  localparam int IW  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int XW  = AW + 1;

  logic [ENTRIES-1:0] vld, st_kill, chk_match, keep, same_reg;
  logic [AW-1:0]      e_addr [ENTRIES];
  logic [1:0]         e_size [ENTRIES];
  logic [RW-1:0]      e_reg  [ENTRIES];
  logic [IW-1:0]      rr, slot;
  logic               use_rr;

  function automatic logic overlaps(input logic [AW-1:0] a, input logic [1:0] sa,
                                    input logic [AW-1:0] b, input logic [1:0] sb);
    logic [XW-1:0] a_lo, a_hi, b_lo, b_hi;
    a_lo = {1'b0, a};
    b_lo = {1'b0, b};
    a_hi = a_lo + (XW'(1) << sa) - XW'(1);
    b_hi = b_lo + (XW'(1) << sb) - XW'(1);
    return (a_lo <= b_hi) && (b_lo <= a_hi);
  endfunction

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      st_kill[i]   = st_valid && vld[i] && overlaps(e_addr[i], e_size[i], st_addr, st_size);
      chk_match[i] = chk_valid && vld[i] && !st_kill[i] && (e_reg[i] == chk_reg);
    end
  end

  assign keep = vld & ~st_kill & ~chk_match;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      same_reg[i] = keep[i] && (e_reg[i] == ld_reg);
  end

  always_comb begin
    slot   = rr;
    use_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!keep[i]) begin
        slot   = IW'(i);
        use_rr = 1'b0;
      end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (same_reg[i]) begin
        slot   = IW'(i);
        use_rr = 1'b0;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      rr        <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      vld <= keep;
      if (ld_valid) begin
        vld[slot] <= 1'b1;
        if (use_rr) rr <= (rr == IW'(ENTRIES - 1)) ? '0 : rr + IW'(1);
      end
      rsp_valid <= chk_valid;
      rsp_hit   <= |chk_match;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid) begin
      e_addr[slot] <= ld_addr;
      e_size[slot] <= ld_size;
      e_reg[slot]  <= ld_reg;
    end
  end
endmodule

module spec_load_table_chk #(
  parameter int ENTRIES = 16,
  parameter int RW      = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic               st_valid,
  input logic               chk_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [ENTRIES-1:0] vld,
  input logic [RW-1:0]      e_reg [ENTRIES]
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (vld[i] && vld[j] && (e_reg[i] == e_reg[j])) dup = 1'b1;
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) $rose(rst_n) |-> (vld == '0));
  a_r2_resp_follows_check: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !rsp_valid);
  a_r3_hit_only_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  a_r4_hit_frees_record: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !$past(ld_valid)) |-> ($countones(vld) < $countones($past(vld))));
  a_r5_store_never_adds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_valid) && !$past(ld_valid)) |-> ($countones(vld) <= $countones($past(vld))));
  a_r6_unique_registers: assert property (@(posedge clk) disable iff (!rst_n) !dup);
endmodule

bind spec_load_table spec_load_table_chk #(.ENTRIES(ENTRIES), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .st_valid(st_valid),
  .chk_valid(chk_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .vld(vld), .e_reg(e_reg)
);

// File: tb/tb_spec_load_table.sv
module tb_spec_load_table;
  localparam int N  = 16;
  localparam int AW = 32;
  localparam int RW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
  logic [AW-1:0] ld_addr = '0, st_addr = '0;
  logic [1:0] ld_size = '0, st_size = '0;
  logic [RW-1:0] ld_reg = '0, chk_reg = '0;
  logic rsp_valid, rsp_hit;

  always #4 clk = ~clk;

  spec_load_table #(.ENTRIES(N), .AW(AW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_reg(ld_reg), .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit));

  int checks = 0, errors = 0;
  bit m_vld [N];
  longint m_addr [N];
  int m_size [N], m_reg [N], m_rr;

  function automatic bit ovl(longint a, int sa, longint b, int sb);
    return (a <= b + (64'd1 << sb) - 1) && (b <= a + (64'd1 << sa) - 1);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) m_vld[i] = 0;
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle of stimulus, starting and ending at a falling edge.
  task automatic step(bit lv, longint la, int ls, int lr, bit sv, longint sa, int ss,
                      bit cv, int cr, string req);
    bit exp_hit = 0;
    bit keep [N];
    int slot = -1;
    ld_valid = lv; ld_addr = AW'(la); ld_size = 2'(ls); ld_reg = RW'(lr);
    st_valid = sv; st_addr = AW'(sa); st_size = 2'(ss);
    chk_valid = cv; chk_reg = RW'(cr);
    for (int i = 0; i < N; i++) begin
      keep[i] = m_vld[i];
      if (sv && keep[i] && ovl(m_addr[i], m_size[i], sa, ss)) keep[i] = 0;
      if (cv && keep[i] && m_reg[i] == cr) begin exp_hit = 1; keep[i] = 0; end
    end
    if (lv) begin
      for (int i = 0; i < N; i++) if (keep[i] && m_reg[i] == lr && slot < 0) slot = i;
      for (int i = 0; i < N; i++) if (!keep[i] && slot < 0) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
      keep[slot] = 1; m_addr[slot] = la; m_size[slot] = ls; m_reg[slot] = lr;
    end
    for (int i = 0; i < N; i++) m_vld[i] = keep[i];
    @(negedge clk);
    ld_valid = 0; st_valid = 0; chk_valid = 0;
    check(rsp_valid === cv, req, "rsp_valid", int'(rsp_valid), int'(cv));
    if (cv) check(rsp_hit === exp_hit, req, "rsp_hit", int'(rsp_hit), int'(exp_hit));
  endtask

  task automatic ld(longint a, int s, int r, string req);
    step(1, a, s, r, 0, 0, 0, 0, 0, req);
  endtask
  task automatic st(longint a, int s, string req);
    step(0, 0, 0, 0, 1, a, s, 0, 0, req);
  endtask
  task automatic ck(int r, string req);
    step(0, 0, 0, 0, 0, 0, 0, 1, r, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    // R1: empty after reset, no response without a check
    check(rsp_valid === 1'b0, "R1", "rsp_valid idle", int'(rsp_valid), 0);
    ck(3, "R1");
    // R2 hit, R4 consumed
    ld(64'h100, 2, 5, "R2");
    ck(5, "R2");
    ck(5, "R4");
    // R3 never-loaded register
    ck(9, "R3");
    // R5 size-aware overlap
    ld(64'h200, 3, 6, "R5");
    st(64'h208, 0, "R5");
    ck(6, "R5");
    ld(64'h200, 3, 6, "R5");
    st(64'h207, 0, "R5");
    ck(6, "R5");
    ld(64'h200, 1, 6, "R5");
    st(64'h1FE, 2, "R5");
    ck(6, "R5");
    ld(64'h200, 0, 6, "R5");
    st(64'h1FC, 2, "R5");
    ck(6, "R5");
    // R6 re-load replaces older record
    ld(64'h300, 2, 7, "R6");
    ld(64'h400, 2, 7, "R6");
    st(64'h300, 2, "R6");
    ck(7, "R6");
    // R8 store before check in the same cycle
    ld(64'h500, 2, 8, "R8");
    step(0, 0, 0, 0, 1, 64'h502, 0, 1, 8, "R8");
    // R9 load after check and store in the same cycle
    step(1, 64'h600, 2, 10, 0, 0, 0, 1, 10, "R9");
    ck(10, "R9");
    step(1, 64'h700, 2, 11, 1, 64'h700, 2, 0, 0, "R9");
    ck(11, "R9");
    // R7 replacement order on a full table
    do_reset();
    for (int r = 0; r < N; r++) ld(64'h1000 + 64'(r) * 16, 2, r, "R7");
    ld(64'h2000, 2, 16, "R7");
    ld(64'h2010, 2, 17, "R7");
    ck(0, "R7");
    ck(1, "R7");
    ck(2, "R7");
    ld(64'h2020, 2, 18, "R7");
    ck(3, "R7");
    ck(16, "R7");
    ck(17, "R7");
    ck(18, "R7");
    // Random mix: R2/R5/R6/R7/R8/R9 against the model
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      bit lv = ($urandom % 3) == 0;
      bit sv = ($urandom % 3) == 0;
      bit cv = ($urandom % 2) == 0;
      step(lv, 64'h8000 + longint'($urandom % 64), int'($urandom % 4), int'($urandom % 20),
           sv, 64'h8000 + longint'($urandom % 64), int'($urandom % 4),
           cv, int'($urandom % 20), "R2_R5_R7_random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule